// File: doc/BRIEF.md
# Register-bank I2C target with burst read pointer

This block is an I2C target that answers to one fixed 7-bit device address and holds a small bank of four byte-wide registers. Sub-addresses 0, 1 and 2 hold the command, dimming and auxiliary settings. These are stored here and can be read and written. Sub-address 3 returns a status byte that comes live from the surrounding logic and cannot be written. The bank's stored values leave the block on dedicated output buses, so the rest of the chip sees each setting as soon as it is written.

A controller writes by sending the device address with the write bit, a sub-address byte and then one data byte. A controller reads by first writing the sub-address. It then issues a repeated START and the device address with the read bit, and receives data. After each byte it reads, the internal pointer moves to the next register. As long as the controller acknowledges, further bytes follow without any address being sent again. A not-acknowledge followed by STOP ends the burst.

The bus lines are oversampled by the system clock. SDA is driven open-drain: the block only ever pulls the line low by raising an output enable. It never stretches SCL.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset, the command, dimming and auxiliary registers read 0x00 and the SDA pull-down enable is low.
- R2: A byte after START whose upper seven bits equal the device address is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the block leaves SDA released for every later byte until a new START.
- R3: A write transfer stores the data byte in the register selected by the sub-address. The register is updated during the acknowledge slot that follows the byte. Sub-address and data bytes are both acknowledged.
- R4: A write to sub-address 0x03 (status) is acknowledged but leaves every stored register unchanged. A read of 0x03 returns the value present on the status input when the byte is loaded.
- R5: After a sub-address write, a repeated START and the device address with the read bit (bit 0 = 1) are acknowledged. The selected register is then shifted out most significant bit first, with each bit placed on SDA while SCL is low.
- R6: After every byte read, the pointer moves to the next sub-address. A controller acknowledge (SDA low in the ninth clock) makes the block send the next register's byte at once.
- R7: During a burst, the pointer moves from sub-address 0x03 back to 0x00.
- R8: Sub-addresses above 0x03 read as 0x00. Writes to them are acknowledged and have no effect on any register.
- R9: A controller not-acknowledge (SDA high in the ninth clock) ends the read. SDA stays released until the next START.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both judged on the synchronized lines. After a STOP, the block ignores bytes until the next START and acknowledges none of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | Pull SDA low when 1; release when 0 |
| status_i | input | 8 | Live status byte returned at sub-address 0x03 |
| cmd_q | output | 8 | Stored command register (sub-address 0x00) |
| dim_q | output | 8 | Stored dimming register (sub-address 0x01) |
| aux_q | output | 8 | Stored auxiliary register (sub-address 0x02) |

## Verification
The properties assume a well-behaved controller. SDA changes only while SCL is low, except when it forms a START or a STOP. Each SCL level lasts longer than the synchronizer delay plus one cycle, so the block's change of the pull-down enable always falls inside a low phase of the raw SCL. The stimulus keeps each SCL phase at eight clocks and holds SDA for half a phase after every falling SCL edge before changing it. It only asks for a repeated START after an acknowledge slot has ended and SDA has been released.

// File: rtl/i2cr_pkg.sv
`timescale 1ns/1ps
package i2cr_pkg;
   localparam int          BYTE_W     = 8;
   localparam int          NUM_RW     = 3;
   localparam int          CNT_W      = $clog2(BYTE_W + 1);
   localparam logic [7:0]  SUB_STATUS = 8'h03;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_SUB, ST_SACK,
      ST_WR, ST_WACK, ST_RD, ST_MACK
   } ctl_state_e;

   // pointer step used after every byte read: the last mapped entry wraps
   function automatic logic [7:0] ptr_next(input logic [7:0] p);
      return (p == SUB_STATUS) ? 8'h00 : p + 8'h01;
   endfunction
endpackage

// File: rtl/i2cr_sync.sv
`timescale 1ns/1ps
module i2cr_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("i2cr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
         prev  <= RST_VAL;
      end else begin
         chain <= {chain[STAGES-2:0], d};
         prev  <= chain[STAGES-1];
      end
   end

   assign q    = chain[STAGES-1];
   assign rise = q & ~prev;
   assign fall = ~q & prev;
endmodule

// File: rtl/i2cr_regfile.sv
`timescale 1ns/1ps
module i2cr_regfile
   import i2cr_pkg::*;
#(
   parameter logic [7:0] RST_CMD = 8'h00,
   parameter logic [7:0] RST_DIM = 8'h00,
   parameter logic [7:0] RST_AUX = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] addr,
   input  logic [7:0] wr_data,
   input  logic [7:0] status_i,
   output logic [7:0] rd_data,
   output logic [7:0] cmd_q,
   output logic [7:0] dim_q,
   output logic [7:0] aux_q
);
   localparam logic [NUM_RW-1:0][7:0] RST_VALS = {RST_AUX, RST_DIM, RST_CMD};

   logic [7:0] store [NUM_RW];

   generate
      for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              store[i] <= RST_VALS[i];
            else if (wr_en && addr == 8'(i))         store[i] <= wr_data;
         end
      end
   endgenerate

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NUM_RW; i++)
         if (addr == 8'(i)) rd_data = store[i];
      if (addr == SUB_STATUS) rd_data = status_i;
   end

   assign cmd_q = store[0];
   assign dim_q = store[1];
   assign aux_q = store[2];
endmodule

// File: rtl/i2cr_ctrl.sv
`timescale 1ns/1ps
module i2cr_ctrl
   import i2cr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h3A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_q,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       sda_q,
   input  logic       sda_rise,
   input  logic       sda_fall,
   input  logic [7:0] rd_data,
   output logic       sda_oe,
   output logic       wr_en,
   output logic [7:0] wr_data,
   output logic [7:0] ptr,
   output logic       ev_start,
   output logic       ev_stop,
   output ctl_state_e st
);
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-2:0] tx;
   logic              rw;
   logic              full;

   assign ev_start = sda_fall & scl_q;
   assign ev_stop  = sda_rise & scl_q;
   assign full     = (cnt == CNT_W'(BYTE_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         tx      <= '0;
         rw      <= 1'b0;
         ptr     <= 8'h00;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_data <= 8'h00;
      end else begin
         wr_en <= 1'b0;
         if (ev_start) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (ev_stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_q};
            if (!full) cnt <= cnt + CNT_W'(1);
         end else if (scl_fall) begin
            unique case (st)
               ST_ADDR: if (full) begin
                  if (shreg[7:1] == DEV_ADDR) begin
                     rw     <= shreg[0];
                     sda_oe <= 1'b1;
                     st     <= ST_AACK;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
               ST_AACK: begin
                  cnt <= '0;
                  if (rw) begin
                     tx     <= rd_data[6:0];
                     sda_oe <= ~rd_data[7];
                     st     <= ST_RD;
                  end else begin
                     sda_oe <= 1'b0;
                     st     <= ST_SUB;
                  end
               end
               ST_SUB: if (full) begin
                  ptr    <= shreg;
                  sda_oe <= 1'b1;
                  st     <= ST_SACK;
               end
               ST_WR: if (full) begin
                  wr_en   <= 1'b1;
                  wr_data <= shreg;
                  sda_oe  <= 1'b1;
                  st      <= ST_WACK;
               end
               ST_SACK, ST_WACK: begin
                  sda_oe <= 1'b0;
                  cnt    <= '0;
                  st     <= ST_WR;
               end
               ST_RD: begin
                  if (full) begin
                     sda_oe <= 1'b0;
                     ptr    <= ptr_next(ptr);
                     st     <= ST_MACK;
                  end else begin
                     sda_oe <= ~tx[6];
                     tx     <= {tx[5:0], 1'b0};
                  end
               end
               ST_MACK: begin
                  if (!shreg[0]) begin
                     tx     <= rd_data[6:0];
                     sda_oe <= ~rd_data[7];
                     cnt    <= '0;
                     st     <= ST_RD;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_regbank_target.sv
`timescale 1ns/1ps
module i2c_regbank_target
   import i2cr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h3A,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] RST_CMD     = 8'h00,
   parameter logic [7:0] RST_DIM     = 8'h00,
   parameter logic [7:0] RST_AUX     = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [7:0] status_i,
   output logic [7:0] cmd_q,
   output logic [7:0] dim_q,
   output logic [7:0] aux_q
);
   generate
      if (DEV_ADDR == 7'h00) begin : g_bad_addr
         $error("i2c_regbank_target: address 0 is reserved for broadcast");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2c_regbank_target: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic       scl_q, scl_rise, scl_fall;
   logic       sda_q, sda_rise, sda_fall;
   logic       wr_en;
   logic [7:0] wr_data, ptr, rd_data;
   logic       ev_start, ev_stop;
   ctl_state_e st;

   i2cr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i),
      .q(scl_q), .rise(scl_rise), .fall(scl_fall));

   i2cr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i),
      .q(sda_q), .rise(sda_rise), .fall(sda_fall));

   i2cr_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .scl_q(scl_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_q(sda_q), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
      .wr_data(wr_data), .ptr(ptr),
      .ev_start(ev_start), .ev_stop(ev_stop), .st(st));

   i2cr_regfile #(.RST_CMD(RST_CMD), .RST_DIM(RST_DIM), .RST_AUX(RST_AUX)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr),
      .wr_data(wr_data), .status_i(status_i), .rd_data(rd_data),
      .cmd_q(cmd_q), .dim_q(dim_q), .aux_q(aux_q));
endmodule

// File: rtl/i2cr_checker.sv
`timescale 1ns/1ps
module i2cr_checker
   import i2cr_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_oe,
   input logic [7:0] cmd_q,
   input logic [7:0] dim_q,
   input logic [7:0] aux_q,
   input logic       ev_start,
   input logic       ev_stop,
   input ctl_state_e st
);
   a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> (st == ST_IDLE) && !sda_oe);

   a_r10_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start |=> (st == ST_ADDR) && !sda_oe);

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   a_r9_master_slot_released: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MACK) |-> !sda_oe);

   a_r3_update_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q != $past(cmd_q) || dim_q != $past(dim_q) || aux_q != $past(aux_q))
         |-> sda_oe);

   a_r5_drive_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_i);
endmodule

bind i2c_regbank_target i2cr_checker u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .cmd_q(cmd_q), .dim_q(dim_q), .aux_q(aux_q),
   .ev_start(ev_start), .ev_stop(ev_stop), .st(st));

// File: tb/tb_i2c_regbank_target.sv
`timescale 1ns/1ps
module tb_i2c_regbank_target;
   localparam logic [6:0] ADDR   = 7'h3A;
   localparam int         H      = 8;   // clocks per SCL phase
   localparam int         WR_LAT = 4;   // two sync flops, edge flop, write flop

   logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
   logic [7:0] status = 8'h3C;
   logic sda_oe;
   logic [7:0] cmd_q, dim_q, aux_q;
   wire  sda_bus;
   assign sda_bus = sda_m & ~sda_oe;

   int n_tests = 0, n_fail = 0;
   logic [7:0] mdl [3];
   bit cmp_on = 1'b0;

   always #2.5 clk = ~clk;

   i2c_regbank_target #(.DEV_ADDR(ADDR)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .status_i(status),
      .cmd_q(cmd_q), .dim_q(dim_q), .aux_q(aux_q));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference register bank compared on every clock (R3, R4, R8)
   always @(negedge clk) if (cmp_on) begin
      check(cmd_q == mdl[0], "R3 cmd_q", cmd_q, mdl[0]);
      check(dim_q == mdl[1], "R3 dim_q", dim_q, mdl[1]);
      check(aux_q == mdl[2], "R3 aux_q", aux_q, mdl[2]);
   end

   function automatic logic [7:0] mread(input int p);
      if (p < 3)  return mdl[p];
      if (p == 3) return status;
      return 8'h00;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0; tick(H/2);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic bit_x(input logic b, output logic r, input int upd, input logic [7:0] val);
      sda_m = b; tick(H);
      scl_m = 1'b1; tick(H/2);
      r = sda_bus; tick(H/2);
      scl_m = 1'b0;
      if (upd >= 0) begin
         tick(WR_LAT-1); #1;
         mdl[upd] = val;
         tick(H/2-WR_LAT+1);
      end else begin
         tick(H/2);
      end
   endtask

   task automatic send_byte(input logic [7:0] v, input int upd, output bit acked);
      logic r;
      for (int i = 7; i >= 0; i--) bit_x(v[i], r, (i == 0) ? upd : -1, v);
      bit_x(1'b1, r, -1, 8'h00);
      acked = (r == 1'b0);
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] v);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_x(1'b1, r, -1, 8'h00);
         v[i] = r;
      end
      bit_x(mack ? 1'b0 : 1'b1, r, -1, 8'h00);
   endtask

   task automatic do_write(input logic [7:0] sub, input logic [7:0] val, input string req);
      bit ack;
      bus_start();
      send_byte({ADDR, 1'b0}, -1, ack);
      check(ack, "R2 address ack on write", ack, 1);
      send_byte(sub, -1, ack);
      check(ack, {req, " sub-address ack"}, ack, 1);
      send_byte(val, (sub < 3) ? int'(sub) : -1, ack);
      check(ack, {req, " data ack"}, ack, 1);
      bus_stop();
   endtask

   task automatic do_read(input logic [7:0] sub, input int n, input string req);
      bit ack;
      logic [7:0] v;
      int p = int'(sub);
      bus_start();
      send_byte({ADDR, 1'b0}, -1, ack);
      check(ack, "R2 address ack", ack, 1);
      send_byte(sub, -1, ack);
      check(ack, "R5 sub-address ack", ack, 1);
      bus_start();
      send_byte({ADDR, 1'b1}, -1, ack);
      check(ack, "R5 read address ack after repeated START", ack, 1);
      for (int k = 0; k < n; k++) begin
         recv_byte(k < n-1, v);
         check(v == mread(p), req, v, mread(p));
         p = (p == 3) ? 0 : (p + 1) % 256;
      end
      check(sda_oe == 1'b0, "R9 SDA released after NACK", sda_oe, 0);
      bus_stop();
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      bit ack;
      for (int i = 0; i < 3; i++) mdl[i] = 8'h00;
      tick(5);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      check(cmd_q == 8'h00, "R1 cmd reset", cmd_q, 0);
      check(dim_q == 8'h00, "R1 dim reset", dim_q, 0);
      check(aux_q == 8'h00, "R1 aux reset", aux_q, 0);
      check(sda_oe == 1'b0, "R1 sda_oe reset", sda_oe, 0);
      cmp_on = 1'b1;

      do_write(8'h00, 8'h5A, "R3 cmd");
      do_write(8'h01, 8'hC3, "R3 dim");
      do_write(8'h02, 8'h81, "R3 aux");
      do_write(8'h03, 8'hFF, "R4 status write");
      do_write(8'h05, 8'h77, "R8 high sub-address write");

      // R2 foreign address: no ack, then silence until next START
      bus_start();
      send_byte({7'h11, 1'b0}, -1, ack);
      check(!ack, "R2 foreign address nack", ack, 0);
      send_byte(8'h00, -1, ack);
      check(!ack, "R2 silent after foreign address", ack, 0);
      bus_stop();

      // R5 R6 R7 burst from sub 1 wrapping to 0, ended by NACK (R9)
      do_read(8'h01, 4, "R6 burst data");
      do_read(8'h03, 2, "R7 wrap data");
      status = 8'hA5;
      do_read(8'h03, 1, "R4 status read");
      do_read(8'h00, 1, "R5 single read");
      do_read(8'h05, 2, "R8 high sub-address reads zero");

      // R10 bytes after STOP without START are ignored
      scl_m = 1'b0; tick(H);
      send_byte({ADDR, 1'b0}, -1, ack);
      check(!ack, "R10 no ack without START", ack, 0);
      check(sda_oe == 1'b0, "R10 SDA released without START", sda_oe, 0);
      scl_m = 1'b1; tick(H);

      finish_run();
   end
endmodule